// File: doc/BRIEF.md
# Capture/Reload Up-Down Timer

A 16-bit timer/counter with a byte-wide register port. It advances either from an internal prescaler (one step every `PRESCALE` system clocks, or every two clocks in the fast modes) or from falling edges of an external count input. A second external input serves as a trigger for capture or forced reload. In the up/down configuration its level picks the count direction instead. Both inputs are sampled on the system clock through a synchronizer and then edge-detected.

Three operating styles share one counter and one 16-bit capture/reload register. Capture mode latches the running count on a trigger edge. Auto-reload mode reloads from the register on rollover, optionally counting down and reloading all ones at underflow. The fast modes run the counter at half the system clock and reload on every rollover. One of them gives a one-cycle rollover pulse for a serial rate generator. The other gives a square wave whose period is four times (65536 minus the reload value) system clocks. An interrupt request is formed from two sticky flags held in the control word.

Top module: `capreload_timer`

## Requirements
- R1: Register addresses are 0 control, 1 mode, 2 count low, 3 count high, 4 reload/capture low, 5 reload/capture high. After reset every register reads 0, and irq, ovfPulse and clkOut are 0.
- R2: Control bits are: bit0 run, bit1 external-count select, bit2 capture select, bit3 trigger enable, bit4 and bit5 rate selects, bit6 overflow flag, bit7 external flag. With run=1 and bits 1, 4 and 5 clear and mode bit1 clear, the counter advances by one every PRESCALE (12) clocks. With run=0 it holds its value.
- R3: With bit1=1 the counter advances once for each falling edge of extCnt. A rising edge has no effect. The new value is visible three clocks after the input changes.
- R4: In capture mode (bit2=1), a rollover from FFFFh yields 0000h and sets the overflow flag, with no reload.
- R5: In capture mode with bit3=1, a falling edge of extTrig copies the counter into the capture register and sets the external flag, leaving the counter unchanged. With bit3=0 the edge changes nothing.
- R6: In auto-reload mode (bit2=0), a rollover from FFFFh loads the reload value and sets the overflow flag. With bit3=1, a falling extTrig edge forces a reload and sets the external flag.
- R7: With mode bit0 (down enable) set in auto-reload mode, extTrig high counts up and low counts down. A down step taken while the counter equals the reload value loads FFFFh and sets the overflow flag. extTrig edges then cause no reload.
- R8: In up/down mode the external flag toggles on every rollover and every underflow. irq is the overflow flag OR'd with the external flag, with the external flag excluded while in up/down mode.
- R9: With bit4 or bit5 set, in timer mode, the counter advances every 2 clocks and reloads on rollover. ovfPulse is high for one clock after each rollover, and the overflow flag is never set.
- R10: With mode bit1 set, bit1 clear and run set, the counter advances every 2 clocks and reloads on rollover. clkOut toggles at each rollover, so its period is 4*(65536-reload) clocks. No flag is set. In counter mode clkOut stays 0.
- R11: Both flags stay set until a write to the control word. That write loads bits 6 and 7 from the written data. A flag event in the same clock takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| extCnt | input | 1 | External count input, falling-edge active |
| extTrig | input | 1 | Trigger (falling edge) or direction level |
| irq | output | 1 | Interrupt request |
| ovfPulse | output | 1 | One-clock pulse after each rollover |
| clkOut | output | 1 | 50% duty-cycle clock output |

## Verification
A wrong prescaler phase or a wrong reload choice shows up in the count registers within one count step. The bench therefore reads the counter after every step of a long run and compares it to an arithmetic model. A flag set in the wrong mode, or a flag that fails to toggle, shows up on irq and in the control word within one clock of the rollover. Clock-out and rate-pulse faults show up as a wrong number of transitions in a window of exactly ten reload periods, swept over several reload values.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_MODE   = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_CAP_LO = 3'd4,
    REG_CAP_HI = 3'd5
  } regSel_e;

  localparam int B_RUN    = 0;
  localparam int B_EXTCNT = 1;
  localparam int B_CAPSEL = 2;
  localparam int B_EXTEN  = 3;
  localparam int B_RATERX = 4;
  localparam int B_RATETX = 5;
  localparam int B_OVF    = 6;
  localparam int B_EXT    = 7;

  localparam int M_DOWN   = 0;
  localparam int M_CLKOUT = 1;

  typedef struct packed {
    logic cntTick;
    logic countDown;
    logic reloadOnWrap;
    logic trigLoad;
    logic trigCapture;
    logic clkOutMode;
    logic wrCntLo;
    logic wrCntHi;
    logic wrCapLo;
    logic wrCapHi;
  } dpStrobe_t;
endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '1;
    else       shReg <= {shReg[STAGES-2:0], din};
  end

  assign dout = shReg[STAGES-1];
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            addr,
  input  logic [BYTE_W-1:0]     wrData,
  output logic [BYTE_W-1:0]     rdData,
  input  logic                  extCnt,
  input  logic                  extTrig,
  input  logic [2*BYTE_W-1:0]   cntVal,
  input  logic [2*BYTE_W-1:0]   capVal,
  input  logic                  wrapUp,
  input  logic                  wrapDown,
  output dpStrobe_t             stb,
  output logic [BYTE_W-1:0]     ctrlWord,
  output logic                  irq
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

  logic [BYTE_W-1:0] ctrlReg, ctrlBase, ctrlNext;
  logic downEn, outEn;
  logic [PRE_W-1:0] presc, prescLimit;
  logic cntSync, trigSync, cntPrev, trigPrev;
  logic cntFall, trigFall;
  logic run, extCount, rateSel;
  logic clkOutMode, rateMode, fastMode, captureMode, reloadMode, updownMode;
  logic presHit, tick;
  logic wrCtrl, wrMode;
  logic setOvf, setExt, togExt;

  crt_sync #(.STAGES(SYNC_STAGES)) u_syncCnt (
    .clk(clk), .rstN(rstN), .din(extCnt), .dout(cntSync)
  );
  crt_sync #(.STAGES(SYNC_STAGES)) u_syncTrig (
    .clk(clk), .rstN(rstN), .din(extTrig), .dout(trigSync)
  );

  assign cntFall  = cntPrev & ~cntSync;
  assign trigFall = trigPrev & ~trigSync;

  // mode decode
  assign run         = ctrlReg[B_RUN];
  assign extCount    = ctrlReg[B_EXTCNT];
  assign rateSel     = ctrlReg[B_RATERX] | ctrlReg[B_RATETX];
  assign clkOutMode  = run & outEn & ~extCount;
  assign rateMode    = run & rateSel;
  assign fastMode    = rateMode | clkOutMode;
  assign captureMode = run & ctrlReg[B_CAPSEL] & ~fastMode;
  assign reloadMode  = run & ~ctrlReg[B_CAPSEL] & ~fastMode;
  assign updownMode  = reloadMode & downEn;

  // prescaler: divides by PRESCALE, or by 2 in the fast modes
  assign prescLimit = fastMode ? PRE_W'(1) : PRE_W'(PRESCALE - 1);
  assign presHit    = (presc >= prescLimit);
  assign tick       = run & (extCount ? cntFall : presHit);

  assign wrCtrl = wrEn & (addr == REG_CTRL);
  assign wrMode = wrEn & (addr == REG_MODE);

  always_comb begin
    stb              = '0;
    stb.cntTick      = tick;
    stb.countDown    = updownMode & ~trigSync;
    stb.reloadOnWrap = ~captureMode;
    stb.trigLoad     = reloadMode & ~downEn & ctrlReg[B_EXTEN] & trigFall;
    stb.trigCapture  = captureMode & ctrlReg[B_EXTEN] & trigFall;
    stb.clkOutMode   = clkOutMode;
    stb.wrCntLo      = wrEn & (addr == REG_CNT_LO);
    stb.wrCntHi      = wrEn & (addr == REG_CNT_HI);
    stb.wrCapLo      = wrEn & (addr == REG_CAP_LO);
    stb.wrCapHi      = wrEn & (addr == REG_CAP_HI);
  end

  // flag events
  assign setOvf = (wrapUp | wrapDown) & ~rateSel & ~clkOutMode;
  assign setExt = stb.trigLoad | stb.trigCapture;
  assign togExt = updownMode & (wrapUp | wrapDown);

  always_comb begin
    ctrlBase        = wrCtrl ? wrData : ctrlReg;
    ctrlNext        = ctrlBase;
    ctrlNext[B_OVF] = ctrlBase[B_OVF] | setOvf;
    ctrlNext[B_EXT] = (ctrlBase[B_EXT] ^ togExt) | setExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      downEn   <= 1'b0;
      outEn    <= 1'b0;
      presc    <= '0;
      cntPrev  <= 1'b1;
      trigPrev <= 1'b1;
    end else begin
      ctrlReg  <= ctrlNext;
      if (wrMode) begin
        downEn <= wrData[M_DOWN];
        outEn  <= wrData[M_CLKOUT];
      end
      if (!run || extCount || presHit) presc <= '0;
      else                             presc <= presc + 1'b1;
      cntPrev  <= cntSync;
      trigPrev <= trigSync;
    end
  end

  always_comb begin
    case (regSel_e'(addr))
      REG_CTRL:   rdData = ctrlReg;
      REG_MODE: begin
        rdData           = '0;
        rdData[M_DOWN]   = downEn;
        rdData[M_CLKOUT] = outEn;
      end
      REG_CNT_LO: rdData = cntVal[BYTE_W-1:0];
      REG_CNT_HI: rdData = cntVal[2*BYTE_W-1:BYTE_W];
      REG_CAP_LO: rdData = capVal[BYTE_W-1:0];
      REG_CAP_HI: rdData = capVal[2*BYTE_W-1:BYTE_W];
      default:    rdData = '0;
    endcase
  end

  assign ctrlWord = ctrlReg;
  assign irq      = ctrlReg[B_OVF] | (ctrlReg[B_EXT] & ~updownMode);
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import crt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [BYTE_W-1:0]   wrByte,
  output logic [2*BYTE_W-1:0] cntVal,
  output logic [2*BYTE_W-1:0] capVal,
  output logic                wrapUp,
  output logic                wrapDown,
  output logic                ovfPulse,
  output logic                clkOut
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntReg, cntNext, capReg, capNext;
  logic clkReg, pulseReg;

  assign wrapUp   = stb.cntTick & ~stb.countDown & (cntReg == CNT_MAX);
  assign wrapDown = stb.cntTick &  stb.countDown & (cntReg == capReg);

  always_comb begin
    cntNext = cntReg;
    if (stb.wrCntLo || stb.wrCntHi) begin
      if (stb.wrCntLo) cntNext[BYTE_W-1:0]     = wrByte;
      if (stb.wrCntHi) cntNext[CNT_W-1:BYTE_W] = wrByte;
    end else if (stb.trigLoad) begin
      cntNext = capReg;
    end else if (wrapUp) begin
      cntNext = stb.reloadOnWrap ? capReg : '0;
    end else if (wrapDown) begin
      cntNext = CNT_MAX;
    end else if (stb.cntTick) begin
      cntNext = stb.countDown ? cntReg - 1'b1 : cntReg + 1'b1;
    end
  end

  always_comb begin
    capNext = capReg;
    if (stb.wrCapLo || stb.wrCapHi) begin
      if (stb.wrCapLo) capNext[BYTE_W-1:0]     = wrByte;
      if (stb.wrCapHi) capNext[CNT_W-1:BYTE_W] = wrByte;
    end else if (stb.trigCapture) begin
      capNext = cntReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg   <= '0;
      capReg   <= '0;
      clkReg   <= 1'b0;
      pulseReg <= 1'b0;
    end else begin
      cntReg   <= cntNext;
      capReg   <= capNext;
      pulseReg <= wrapUp | wrapDown;
      if (!stb.clkOutMode) clkReg <= 1'b0;
      else if (wrapUp)     clkReg <= ~clkReg;
    end
  end

  assign cntVal   = cntReg;
  assign capVal   = capReg;
  assign ovfPulse = pulseReg;
  assign clkOut   = clkReg;
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import crt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              extCnt,
  input  logic              extTrig,
  output logic              irq,
  output logic              ovfPulse,
  output logic              clkOut
);
  localparam int CNT_W = 2 * BYTE_W;

  dpStrobe_t         stb;
  logic [CNT_W-1:0]  cntVal, capVal;
  logic              wrapUp, wrapDown;
  logic [BYTE_W-1:0] ctrlWord;

  crt_ctrl #(
    .BYTE_W(BYTE_W), .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extCnt(extCnt), .extTrig(extTrig),
    .cntVal(cntVal), .capVal(capVal), .wrapUp(wrapUp), .wrapDown(wrapDown),
    .stb(stb), .ctrlWord(ctrlWord), .irq(irq)
  );

  crt_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrData),
    .cntVal(cntVal), .capVal(capVal), .wrapUp(wrapUp), .wrapDown(wrapDown),
    .ovfPulse(ovfPulse), .clkOut(clkOut)
  );
endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          addr,
  input dpStrobe_t           stb,
  input logic [2*BYTE_W-1:0] cntVal,
  input logic [2*BYTE_W-1:0] capVal,
  input logic                wrapUp,
  input logic                wrapDown,
  input logic [BYTE_W-1:0]   ctrlWord,
  input logic                ovfPulse,
  input logic                clkOut
);
  logic wrCnt, wrCap, wrCtrl, rateSel;
  assign wrCnt   = stb.wrCntLo | stb.wrCntHi;
  assign wrCap   = stb.wrCapLo | stb.wrCapHi;
  assign wrCtrl  = wrEn && (addr == 3'd0);
  assign rateSel = ctrlWord[B_RATERX] | ctrlWord[B_RATETX];

  assert_capture_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrapUp && !stb.reloadOnWrap && !wrCnt) |=> (cntVal == '0));

  assert_capture_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.trigCapture && !wrCap) |=> (capVal == $past(cntVal)));

  assert_up_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrapUp && stb.reloadOnWrap && !stb.trigLoad && !wrCnt) |=> (cntVal == $past(capVal)));

  assert_down_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrapDown && !stb.trigLoad && !wrCnt) |=> (cntVal == '1));

  assert_no_flag_rate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel && !wrCtrl) |=> !$rose(ctrlWord[B_OVF]));

  assert_wrap_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrapUp || wrapDown) |=> ovfPulse);

  assert_clkout_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clkOutMode && !wrapUp) |=> $stable(clkOut));
endmodule

bind capreload_timer crt_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .stb(stb),
  .cntVal(cntVal), .capVal(capVal), .wrapUp(wrapUp), .wrapDown(wrapDown),
  .ctrlWord(ctrlWord), .ovfPulse(ovfPulse), .clkOut(clkOut)
);

// File: tb/sim_capreload_timer.sv
`timescale 1ns/1ps
module sim_capreload_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic extCnt = 1'b1;
  logic extTrig = 1'b1;
  logic irq, ovfPulse, clkOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capreload_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extCnt(extCnt), .extTrig(extTrig),
    .irq(irq), .ovfPulse(ovfPulse), .clkOut(clkOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    addr = a;        #1; v[7:0]  = rdData;
    addr = a + 3'd1; #1; v[15:8] = rdData;
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic setCap(input logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCnt();
    extCnt = 1'b0; waitN(4);
    extCnt = 1'b1; waitN(4);
  endtask

  logic [15:0] v16, expV;
  logic [7:0] v8;
  int nEv;
  logic prevClk;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(2);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd8(3'(a), v8);
      check("R1 reset register", 32'(v8), 32'h0);
    end
    check("R1 reset irq", 32'(irq), 32'h0);
    check("R1 reset clkOut", 32'(clkOut), 32'h0);
    check("R1 reset ovfPulse", 32'(ovfPulse), 32'h0);

    // R2: timer mode steps once per 12 clocks, freezes when stopped
    setCnt(16'h1234);
    wr(3'd0, 8'h01);
    for (int k = 1; k <= 20; k++) begin
      waitN(12);
      rd16(3'd2, v16);
      check("R2 timer step", 32'(v16), 32'(16'h1234 + k));
    end
    wr(3'd0, 8'h00);
    waitN(30);
    rd16(3'd2, v16);
    check("R2 stopped hold", 32'(v16), 32'(16'h1234 + 20));

    // R4: capture-mode rollover to zero, flag set
    setCnt(16'hFFFE);
    wr(3'd0, 8'h05);
    waitN(36);
    rd16(3'd2, v16);
    check("R4 wrap to zero", 32'(v16), 32'h0001);
    rd8(3'd0, v8);
    check("R4 overflow flag", 32'(v8), 32'h45);
    check("R4 irq", 32'(irq), 32'h1);

    // R11: flags sticky until written
    wr(3'd0, 8'h44);
    waitN(20);
    check("R11 flag sticky irq", 32'(irq), 32'h1);
    wr(3'd0, 8'h04);
    rd8(3'd0, v8);
    check("R11 flag cleared", 32'(v8), 32'h04);
    check("R11 irq cleared", 32'(irq), 32'h0);
    wr(3'd0, 8'h00);

    // R6: up-count auto-reload sweep against arithmetic model
    setCap(16'hFFF0);
    setCnt(16'hFFFD);
    expV = 16'hFFFD;
    wr(3'd0, 8'h01);
    for (int k = 0; k < 40; k++) begin
      waitN(12);
      expV = (expV == 16'hFFFF) ? 16'hFFF0 : expV + 16'd1;
      rd16(3'd2, v16);
      check("R6 reload sequence", 32'(v16), 32'(expV));
    end
    rd8(3'd0, v8);
    check("R6 overflow flag", 32'(v8), 32'h41);
    wr(3'd0, 8'h00);

    // R3: counter mode, falling edges only
    setCnt(16'h00F0);
    wr(3'd0, 8'h03);
    for (int k = 1; k <= 20; k++) begin
      extCnt = 1'b0; waitN(4);
      rd16(3'd2, v16);
      check("R3 falling edge counts", 32'(v16), 32'(16'h00F0 + k));
      extCnt = 1'b1; waitN(4);
      rd16(3'd2, v16);
      check("R3 rising edge ignored", 32'(v16), 32'(16'h00F0 + k));
    end

    // R5: capture on trigger edge with counter static
    setCap(16'h0000);
    wr(3'd0, 8'h0F);
    for (int i = 0; i < 8; i++) begin
      expV = (16'h1111 * 16'(i)) ^ 16'h0F0F;
      setCnt(expV);
      extTrig = 1'b0; waitN(4);
      rd16(3'd4, v16);
      check("R5 captured value", 32'(v16), 32'(expV));
      rd16(3'd2, v16);
      check("R5 counter unchanged", 32'(v16), 32'(expV));
      rd8(3'd0, v8);
      check("R5 external flag", 32'(v8), 32'h8F);
      extTrig = 1'b1; waitN(4);
      wr(3'd0, 8'h0F);
    end
    wr(3'd0, 8'h07);
    setCnt(16'hBEEF);
    extTrig = 1'b0; waitN(4);
    rd16(3'd4, v16);
    check("R5 trigger disabled no capture", 32'(v16), 32'(expV));
    rd8(3'd0, v8);
    check("R5 trigger disabled no flag", 32'(v8), 32'h07);
    check("R5 trigger disabled irq", 32'(irq), 32'h0);
    extTrig = 1'b1; waitN(4);

    // R6: trigger-forced reload
    wr(3'd0, 8'h0B);
    setCap(16'hABCD);
    setCnt(16'h0055);
    extTrig = 1'b0; waitN(4);
    rd16(3'd2, v16);
    check("R6 trigger reload", 32'(v16), 32'hABCD);
    rd8(3'd0, v8);
    check("R6 trigger flag", 32'(v8), 32'h8B);
    check("R6 trigger irq", 32'(irq), 32'h1);
    extTrig = 1'b1; waitN(4);
    wr(3'd0, 8'h00);

    // R7/R8: up/down counting
    wr(3'd1, 8'h01);
    setCap(16'h0003);
    setCnt(16'h0006);
    wr(3'd0, 8'h0B);
    extTrig = 1'b0; waitN(4);
    rd16(3'd2, v16);
    check("R7 trigger edge no reload", 32'(v16), 32'h0006);
    rd8(3'd0, v8);
    check("R7 trigger edge no flag", 32'(v8), 32'h0B);
    expV = 16'h0006;
    for (int k = 0; k < 3; k++) begin
      pulseCnt();
      expV = expV - 16'd1;
      rd16(3'd2, v16);
      check("R7 down step", 32'(v16), 32'(expV));
    end
    pulseCnt();
    rd16(3'd2, v16);
    check("R7 underflow loads all ones", 32'(v16), 32'hFFFF);
    rd8(3'd0, v8);
    check("R8 ext toggled on underflow", 32'(v8), 32'hCB);
    check("R8 irq from overflow flag", 32'(irq), 32'h1);
    wr(3'd0, 8'h8B);
    check("R8 ext flag excluded in up/down", 32'(irq), 32'h0);
    extTrig = 1'b1; waitN(4);
    pulseCnt();
    rd16(3'd2, v16);
    check("R7 up rollover reload", 32'(v16), 32'h0003);
    rd8(3'd0, v8);
    check("R8 ext toggled on rollover", 32'(v8), 32'h4B);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h8B);
    check("R8 ext flag counts outside up/down", 32'(irq), 32'h1);
    wr(3'd0, 8'h00);

    // R9: rate mode pulses, both select bits
    for (int s = 0; s < 2; s++) begin
      setCap(16'hFFF8);
      setCnt(16'hFFF8);
      wr(3'd0, (s == 0) ? 8'h11 : 8'h21);
      nEv = 0;
      for (int c = 0; c < 160; c++) begin
        @(negedge clk);
        if (ovfPulse) nEv++;
      end
      check("R9 rate pulses in ten periods", 32'(nEv), 32'd10);
      rd8(3'd0, v8);
      check("R9 no overflow flag", 32'(v8), (s == 0) ? 32'h11 : 32'h21);
      wr(3'd0, 8'h00);
    end

    // R10: clock-out period sweep
    wr(3'd1, 8'h02);
    for (int r = 0; r < 4; r++) begin
      case (r)
        0: expV = 16'hFFFF;
        1: expV = 16'hFFFE;
        2: expV = 16'hFFFC;
        default: expV = 16'hFFF0;
      endcase
      setCap(expV);
      setCnt(expV);
      wr(3'd0, 8'h01);
      nEv = 0;
      prevClk = clkOut;
      for (int c = 0; c < 20 * (65536 - int'(expV)); c++) begin
        @(negedge clk);
        if (clkOut !== prevClk) nEv++;
        prevClk = clkOut;
      end
      check("R10 clkOut toggles in ten periods", 32'(nEv), 32'd10);
      rd8(3'd0, v8);
      check("R10 no flag in clock-out", 32'(v8), 32'h01);
      check("R10 no irq in clock-out", 32'(irq), 32'h0);
      wr(3'd0, 8'h00);
    end
    setCnt(16'hFFFE);
    setCap(16'hFFFE);
    wr(3'd0, 8'h03);
    nEv = 0;
    for (int k = 0; k < 6; k++) begin
      pulseCnt();
      if (clkOut) nEv++;
    end
    check("R10 counter mode keeps clkOut low", 32'(nEv), 32'd0);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule